// File: doc/BRIEF.md
# Packed FMA Operand Router

This block stands in front of a fused multiply-add datapath that works on 64-bit double-precision lanes. One handshake accepts three 256-bit source vectors, an operation byte and a vector-length bit. The first source is also the destination. The operation byte chooses which source feeds each multiplier input and which source becomes the addend. The router registers the request. On the next cycle it presents, for every lane, two multiplicands, an unmodified addend and a negate control. Even lanes add the addend and odd lanes subtract it. It also presents a lane-valid mask.

The datapath applies the sign inside its single-rounding sum, so the addend itself is never sign-flipped on a rounded path. When the datapath answers, a writeback merge builds the destination vector from the lane results. It clears the upper half for the 128-bit form and ORs the returned per-lane exception flags over the valid lanes only. An unrecognised operation byte raises an illegal flag, enables no lane and completes without waiting for the datapath.

The control sequence has four states:
- IDLE (ready to accept). The transition "accept" moves to ISSUE on `in_valid`.
- ISSUE (routed operands valid for one cycle). "dispatch" moves to WAIT for a legal code. "reject" moves straight to DONE for an illegal code.
- WAIT (awaiting the datapath). "hold" stays in WAIT while `res_valid` is low. "return" moves to DONE on `res_valid`.
- DONE (writeback valid for one cycle). "retire" moves back to IDLE.

Top module: `fma_operand_router`

## Requirements
- R1: `in_ready` is high only in IDLE. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `op_valid` is high for exactly the single cycle after that edge, and `in_ready` stays low until the writeback cycle has passed.
- R2: Operation byte 0x97 routes, per lane, multiplicand A = first source, multiplicand B = third source, addend = second source.
- R3: Operation byte 0xA7 routes multiplicand A = second source, multiplicand B = first source, addend = third source.
- R4: Operation byte 0xB7 routes multiplicand A = second source, multiplicand B = third source, addend = first source.
- R5: `op_negate[i]` is 1 for a valid odd lane (1 or 3) and 0 for even lanes. The addend bits are passed unaltered.
- R6: `op_lane_valid` is 4'b1111 when `in_long`=1 and 4'b0011 when `in_long`=0.
- R7: Any other operation byte gives `op_illegal`=1, `op_lane_valid`=0, `op_negate`=0 and all routed operands zero. The next cycle is writeback, with `wb_illegal`=1, `wb_dest` equal to the first source and `wb_flags`=0.
- R8: A `res_valid` taken in WAIT produces `wb_valid` one cycle later. Each valid lane of `wb_dest` equals the matching 64-bit lane of `res_data`. Without `res_valid` the block stays in WAIT.
- R9: In the 128-bit form, `wb_dest[255:128]` is zero whatever `res_data` holds there.
- R10: `wb_flags` is the OR of the 5-bit per-lane fields `res_flags[5i+4:5i]` over valid lanes only. Lanes 2 and 3 are ignored in the 128-bit form.
- R11: `res_valid` outside WAIT is ignored and produces no `wb_valid`.
- R12: After reset, `in_ready`=1, `op_valid`=0 and `wb_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Router can accept a request |
| in_opcode | input | 8 | Operation byte selecting the operand ordering |
| in_long | input | 1 | 1 = 256-bit form, 0 = 128-bit form |
| in_src1 | input | 256 | First source, also the destination |
| in_src2 | input | 256 | Second source |
| in_src3 | input | 256 | Third source |
| op_valid | output | 1 | Routed operands valid |
| op_mul_a | output | 256 | Per-lane multiplicand A |
| op_mul_b | output | 256 | Per-lane multiplicand B |
| op_addend | output | 256 | Per-lane addend, never negated |
| op_negate | output | 4 | Per-lane subtract control |
| op_lane_valid | output | 4 | Lanes to compute |
| op_illegal | output | 1 | Operation byte not recognised |
| res_valid | input | 1 | Datapath results present |
| res_data | input | 256 | Per-lane rounded results |
| res_flags | input | 20 | Per-lane 5-bit exception fields |
| wb_valid | output | 1 | Writeback vector valid |
| wb_dest | output | 256 | Merged destination vector |
| wb_flags | output | 5 | Sticky flags over valid lanes |
| wb_illegal | output | 1 | Writeback of a rejected request |

## Verification
Routed operands, mask, negate and illegal flag are due in the cycle after the accepting edge. The bench reads them at the falling edge that follows that edge. Writeback is due one cycle after the edge that takes `res_valid` in WAIT, or one cycle after ISSUE for an illegal code. The bench therefore drives `res_valid` for exactly one WAIT cycle and samples `wb_*` at the next falling edge. The datapath's arithmetic is modelled by the bench from the routed outputs. The expected destination, however, is computed directly from the sources and the ordering rules, so a misroute shows up as a wrong value.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fmr_state_e;

    typedef enum logic [1:0] {
        ORD_AC_B,
        ORD_BA_C,
        ORD_BC_A,
        ORD_NONE
    } fmr_order_e;

    localparam logic [7:0] OPC_AC_B = 8'h97;
    localparam logic [7:0] OPC_BA_C = 8'hA7;
    localparam logic [7:0] OPC_BC_A = 8'hB7;

endpackage

// File: rtl/fmr_decode.sv
module fmr_decode
    import fmr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [7:0]       opcode,
    input  logic             long_form,
    output fmr_order_e       order,
    output logic             illegal,
    output logic [LANES-1:0] lane_mask
);

    localparam int HALF = LANES / 2;

    always_comb begin
        case (opcode)
            OPC_AC_B: order = ORD_AC_B;
            OPC_BA_C: order = ORD_BA_C;
            OPC_BC_A: order = ORD_BC_A;
            default:  order = ORD_NONE;
        endcase
    end

    assign illegal = (order == ORD_NONE);

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        if (i < HALF) begin : g_low
            assign lane_mask[i] = !illegal;
        end else begin : g_high
            assign lane_mask[i] = !illegal && long_form;
        end
    end

endmodule

// File: rtl/fmr_lane_mux.sv
module fmr_lane_mux
    import fmr_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter bit ODD    = 1'b0
) (
    input  logic [LANE_W-1:0] src1,
    input  logic [LANE_W-1:0] src2,
    input  logic [LANE_W-1:0] src3,
    input  fmr_order_e        order,
    input  logic              lane_en,
    output logic [LANE_W-1:0] mul_a,
    output logic [LANE_W-1:0] mul_b,
    output logic [LANE_W-1:0] addend,
    output logic              negate
);

    always_comb begin
        mul_a  = '0;
        mul_b  = '0;
        addend = '0;
        unique case (order)
            ORD_AC_B: begin
                mul_a  = src1;
                mul_b  = src3;
                addend = src2;
            end
            ORD_BA_C: begin
                mul_a  = src2;
                mul_b  = src1;
                addend = src3;
            end
            ORD_BC_A: begin
                mul_a  = src2;
                mul_b  = src3;
                addend = src1;
            end
            ORD_NONE: begin
                mul_a  = '0;
                mul_b  = '0;
                addend = '0;
            end
        endcase
        negate = lane_en & ODD;
    end

endmodule

// File: rtl/fmr_wb_merge.sv
module fmr_wb_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 64,
    parameter int FLAG_W = 5
) (
    input  logic [LANES*LANE_W-1:0] dest,
    input  logic [LANES*LANE_W-1:0] res,
    input  logic [LANES*FLAG_W-1:0] lane_flags,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    illegal,
    output logic [LANES*LANE_W-1:0] merged,
    output logic [FLAG_W-1:0]       flag_or
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (illegal) begin
                merged[i*LANE_W +: LANE_W] = dest[i*LANE_W +: LANE_W];
            end else if (lane_mask[i]) begin
                merged[i*LANE_W +: LANE_W] = res[i*LANE_W +: LANE_W];
            end else begin
                merged[i*LANE_W +: LANE_W] = '0;
            end
        end
    end

    always_comb begin
        flag_or = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_mask[i]) begin
                flag_or = flag_or | lane_flags[i*FLAG_W +: FLAG_W];
            end
        end
    end

endmodule

// File: rtl/fma_operand_router.sv
module fma_operand_router
    import fmr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 64,
    parameter int FLAG_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [7:0]              in_opcode,
    input  logic                    in_long,
    input  logic [LANES*LANE_W-1:0] in_src1,
    input  logic [LANES*LANE_W-1:0] in_src2,
    input  logic [LANES*LANE_W-1:0] in_src3,
    output logic                    op_valid,
    output logic [LANES*LANE_W-1:0] op_mul_a,
    output logic [LANES*LANE_W-1:0] op_mul_b,
    output logic [LANES*LANE_W-1:0] op_addend,
    output logic [LANES-1:0]        op_negate,
    output logic [LANES-1:0]        op_lane_valid,
    output logic                    op_illegal,
    input  logic                    res_valid,
    input  logic [LANES*LANE_W-1:0] res_data,
    input  logic [LANES*FLAG_W-1:0] res_flags,
    output logic                    wb_valid,
    output logic [LANES*LANE_W-1:0] wb_dest,
    output logic [FLAG_W-1:0]       wb_flags,
    output logic                    wb_illegal
);

    localparam int VEC_W = LANES * LANE_W;

    fmr_state_e state_q, state_d;

    logic [7:0]       opc_q;
    logic             long_q;
    logic [VEC_W-1:0] s1_q, s2_q, s3_q;

    fmr_order_e       order;
    logic             dec_illegal;
    logic [LANES-1:0] lane_mask;
    logic             issuing;
    logic             wb_load;
    logic [VEC_W-1:0] merged;
    logic [FLAG_W-1:0] flag_or;

    fmr_decode #(.LANES(LANES)) u_decode (
        .opcode    (opc_q),
        .long_form (long_q),
        .order     (order),
        .illegal   (dec_illegal),
        .lane_mask (lane_mask)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = dec_illegal ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (res_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q  <= '0;
            long_q <= 1'b0;
            s1_q   <= '0;
            s2_q   <= '0;
            s3_q   <= '0;
        end else if (in_valid && in_ready) begin
            opc_q  <= in_opcode;
            long_q <= in_long;
            s1_q   <= in_src1;
            s2_q   <= in_src2;
            s3_q   <= in_src3;
        end
    end

    assign issuing = (state_q == ST_ISSUE);

    for (genvar i = 0; i < LANES; i++) begin : g_route
        fmr_lane_mux #(
            .LANE_W (LANE_W),
            .ODD    ((i % 2) == 1)
        ) u_lane (
            .src1    (s1_q[i*LANE_W +: LANE_W]),
            .src2    (s2_q[i*LANE_W +: LANE_W]),
            .src3    (s3_q[i*LANE_W +: LANE_W]),
            .order   (order),
            .lane_en (lane_mask[i] & issuing),
            .mul_a   (op_mul_a[i*LANE_W +: LANE_W]),
            .mul_b   (op_mul_b[i*LANE_W +: LANE_W]),
            .addend  (op_addend[i*LANE_W +: LANE_W]),
            .negate  (op_negate[i])
        );
    end

    fmr_wb_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .FLAG_W (FLAG_W)
    ) u_merge (
        .dest       (s1_q),
        .res        (res_data),
        .lane_flags (res_flags),
        .lane_mask  (lane_mask),
        .illegal    (dec_illegal),
        .merged     (merged),
        .flag_or    (flag_or)
    );

    assign wb_load = ((state_q == ST_WAIT) && res_valid) || (issuing && dec_illegal);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_dest    <= '0;
            wb_flags   <= '0;
            wb_illegal <= 1'b0;
        end else if (wb_load) begin
            wb_dest    <= merged;
            wb_flags   <= flag_or;
            wb_illegal <= dec_illegal;
        end
    end

    // state-decoded outputs
    always_comb begin
        in_ready      = (state_q == ST_IDLE);
        op_valid      = issuing;
        op_lane_valid = issuing ? lane_mask : '0;
        op_illegal    = issuing && dec_illegal;
        wb_valid      = (state_q == ST_DONE);
    end

endmodule

// File: rtl/fmr_checker.sv
module fmr_checker
    import fmr_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 64,
    parameter int FLAG_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [7:0]              in_opcode,
    input logic                    in_long,
    input logic [LANES*LANE_W-1:0] in_src1,
    input logic [LANES*LANE_W-1:0] in_src2,
    input logic [LANES*LANE_W-1:0] in_src3,
    input logic                    op_valid,
    input logic [LANES*LANE_W-1:0] op_mul_a,
    input logic [LANES*LANE_W-1:0] op_mul_b,
    input logic [LANES*LANE_W-1:0] op_addend,
    input logic [LANES-1:0]        op_negate,
    input logic [LANES-1:0]        op_lane_valid,
    input logic                    op_illegal,
    input logic                    res_valid,
    input logic                    wb_valid,
    input logic [FLAG_W-1:0]       wb_flags,
    input logic                    wb_illegal
);

    localparam int HALF = LANES / 2;

    function automatic logic [LANES-1:0] even_lanes();
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = ((i % 2) == 0);
        return m;
    endfunction

    localparam logic [LANES-1:0] EVEN_MASK = even_lanes();

    logic accept;
    assign accept = in_valid && in_ready;

    AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> op_valid); // R1
    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || wb_valid) |-> !in_ready); // R1
    AST_ROUTE_AC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_opcode == OPC_AC_B) |=>
        (op_mul_a == $past(in_src1) && op_mul_b == $past(in_src3) && op_addend == $past(in_src2))); // R2
    AST_ROUTE_BA_C: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_opcode == OPC_BA_C) |=>
        (op_mul_a == $past(in_src2) && op_mul_b == $past(in_src1) && op_addend == $past(in_src3))); // R3
    AST_ROUTE_BC_A: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_opcode == OPC_BC_A) |=>
        (op_mul_a == $past(in_src2) && op_mul_b == $past(in_src3) && op_addend == $past(in_src1))); // R4
    AST_NEGATE_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_negate & (EVEN_MASK | ~op_lane_valid)) == '0); // R5
    AST_SHORT_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_long) |=> (op_lane_valid[LANES-1:HALF] == '0)); // R6
    AST_ILLEGAL_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> (op_lane_valid == '0 && op_valid)); // R7
    AST_ILLEGAL_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_illegal) |-> (wb_flags == '0)); // R7
    AST_ILLEGAL_SKIPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |=> wb_valid); // R7
    AST_RES_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !in_ready && !op_valid && !wb_valid) |=> wb_valid); // R8
    AST_IDLE_RES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && res_valid) |=> !wb_valid); // R11

endmodule

bind fma_operand_router fmr_checker #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .FLAG_W (FLAG_W)
) u_fmr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_opcode     (in_opcode),
    .in_long       (in_long),
    .in_src1       (in_src1),
    .in_src2       (in_src2),
    .in_src3       (in_src3),
    .op_valid      (op_valid),
    .op_mul_a      (op_mul_a),
    .op_mul_b      (op_mul_b),
    .op_addend     (op_addend),
    .op_negate     (op_negate),
    .op_lane_valid (op_lane_valid),
    .op_illegal    (op_illegal),
    .res_valid     (res_valid),
    .wb_valid      (wb_valid),
    .wb_flags      (wb_flags),
    .wb_illegal    (wb_illegal)
);

// File: tb/tb_fma_operand_router.sv
module tb_fma_operand_router;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 4;
    localparam int LANE_W = 64;
    localparam int FLAG_W = 5;
    localparam int VEC_W  = LANES * LANE_W;
    localparam int NVEC   = 8;

    typedef struct packed {
        logic [7:0]  opc;
        logic        lng;
        logic [7:0]  base;
        logic [19:0] flg;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h97, 1'b1, 8'd3, 20'h00011},
        '{8'hA7, 1'b1, 8'd5, 20'h80000},
        '{8'hB7, 1'b1, 8'd7, 20'h00420},
        '{8'h97, 1'b0, 8'd2, 20'hFFC00},
        '{8'hA7, 1'b0, 8'd4, 20'hF8042},
        '{8'hB7, 1'b0, 8'd6, 20'h0030C},
        '{8'h98, 1'b1, 8'd9, 20'hFFFFF},
        '{8'hB6, 1'b0, 8'd1, 20'h12345}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_opcode = '0;
    logic in_long = 1'b0;
    logic [VEC_W-1:0] in_src1 = '0, in_src2 = '0, in_src3 = '0;
    logic op_valid;
    logic [VEC_W-1:0] op_mul_a, op_mul_b, op_addend;
    logic [LANES-1:0] op_negate, op_lane_valid;
    logic op_illegal;
    logic res_valid = 1'b0;
    logic [VEC_W-1:0] res_data = '0;
    logic [LANES*FLAG_W-1:0] res_flags = '0;
    logic wb_valid;
    logic [VEC_W-1:0] wb_dest;
    logic [FLAG_W-1:0] wb_flags;
    logic wb_illegal;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_operand_router #(.LANES(LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_long(in_long),
        .in_src1(in_src1), .in_src2(in_src2), .in_src3(in_src3),
        .op_valid(op_valid), .op_mul_a(op_mul_a), .op_mul_b(op_mul_b),
        .op_addend(op_addend), .op_negate(op_negate),
        .op_lane_valid(op_lane_valid), .op_illegal(op_illegal),
        .res_valid(res_valid), .res_data(res_data), .res_flags(res_flags),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_flags(wb_flags),
        .wb_illegal(wb_illegal)
    );

    task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_val(input int base, input int k, input int i);
        return $realtobits(real'(base + 10 * k + i));
    endfunction

    function automatic logic [VEC_W-1:0] make_src(input int base, input int k);
        logic [VEC_W-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*LANE_W +: LANE_W] = lane_val(base, k, i);
        return v;
    endfunction

    function automatic bit legal(input logic [7:0] opc);
        return opc == 8'h97 || opc == 8'hA7 || opc == 8'hB7;
    endfunction

    // per-lane source pick (k = 1,2,3) for role r: 0 mul A, 1 mul B, 2 addend
    function automatic int pick(input logic [7:0] opc, input int r);
        if (opc == 8'h97) return (r == 0) ? 1 : (r == 1) ? 3 : 2;
        if (opc == 8'hA7) return (r == 0) ? 2 : (r == 1) ? 1 : 3;
        return (r == 0) ? 2 : (r == 1) ? 3 : 1;
    endfunction

    task automatic run_vec(input vec_t v, input int stall);
        logic [VEC_W-1:0] s [1:3];
        logic [VEC_W-1:0] ea, eb, ec, ewb, rd;
        logic [LANES-1:0] emask, eneg;
        logic [FLAG_W-1:0] eflg;
        bit ok;
        string rq;
        ok = legal(v.opc);
        for (int k = 1; k <= 3; k++) s[k] = make_src(int'(v.base), k);
        emask = !ok ? 4'b0000 : (v.lng ? 4'b1111 : 4'b0011);
        eneg  = emask & 4'b1010;
        ea = '0; eb = '0; ec = '0;
        if (ok) begin
            ea = s[pick(v.opc, 0)];
            eb = s[pick(v.opc, 1)];
            ec = s[pick(v.opc, 2)];
        end
        rq = (v.opc == 8'h97) ? "R2" : (v.opc == 8'hA7) ? "R3" : (v.opc == 8'hB7) ? "R4" : "R7";
        eflg = '0;
        ewb = '0;
        for (int i = 0; i < LANES; i++) begin
            if (emask[i]) begin
                real x;
                eflg = eflg | v.flg[i*FLAG_W +: FLAG_W];
                x = $bitstoreal(lane_val(int'(v.base), pick(v.opc, 0), i)) *
                    $bitstoreal(lane_val(int'(v.base), pick(v.opc, 1), i));
                if ((i % 2) == 1) x = x - $bitstoreal(lane_val(int'(v.base), pick(v.opc, 2), i));
                else              x = x + $bitstoreal(lane_val(int'(v.base), pick(v.opc, 2), i));
                ewb[i*LANE_W +: LANE_W] = $realtobits(x);
            end
        end
        if (!ok) ewb = s[1];

        @(negedge clk);
        chk("R1 ready before request", VEC_W'(in_ready), VEC_W'(1));
        in_valid = 1'b1; in_opcode = v.opc; in_long = v.lng;
        in_src1 = s[1]; in_src2 = s[2]; in_src3 = s[3];
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 op_valid after accept", VEC_W'(op_valid), VEC_W'(1));
        chk("R6 R7 lane mask", VEC_W'(op_lane_valid), VEC_W'(emask));
        chk("R5 negate", VEC_W'(op_negate), VEC_W'(eneg));
        chk("R7 illegal flag", VEC_W'(op_illegal), VEC_W'(!ok));
        chk({rq, " mul_a"}, op_mul_a, ea);
        chk({rq, " mul_b"}, op_mul_b, eb);
        chk({rq, " R5 addend"}, op_addend, ec);
        if (ok) begin
            rd = '0;
            for (int i = 0; i < LANES; i++) begin
                if (op_lane_valid[i]) begin
                    real c;
                    c = $bitstoreal(op_addend[i*LANE_W +: LANE_W]);
                    rd[i*LANE_W +: LANE_W] = $realtobits(
                        $bitstoreal(op_mul_a[i*LANE_W +: LANE_W]) *
                        $bitstoreal(op_mul_b[i*LANE_W +: LANE_W]) + (op_negate[i] ? -c : c));
                end else begin
                    rd[i*LANE_W +: LANE_W] = 64'hBAD0_BAD0_BAD0_0000 | 64'(i);
                end
            end
            for (int w = 0; w < stall; w++) begin
                @(negedge clk);
                chk("R8 held in wait", VEC_W'(wb_valid), VEC_W'(0));
                chk("R1 not ready in wait", VEC_W'(in_ready), VEC_W'(0));
            end
            @(negedge clk);
            res_valid = 1'b1; res_data = rd; res_flags = v.flg;
            @(negedge clk);
            res_valid = 1'b0; res_data = '0; res_flags = '0;
            chk("R8 wb_valid", VEC_W'(wb_valid), VEC_W'(1));
            chk(v.lng ? "R8 wb_dest" : "R8 R9 wb_dest", wb_dest, ewb);
            chk("R10 wb_flags", VEC_W'(wb_flags), VEC_W'(eflg));
            chk("R8 wb_illegal low", VEC_W'(wb_illegal), VEC_W'(0));
        end else begin
            @(negedge clk);
            chk("R7 wb_valid", VEC_W'(wb_valid), VEC_W'(1));
            chk("R7 wb_dest keeps src1", wb_dest, ewb);
            chk("R7 wb_flags zero", VEC_W'(wb_flags), VEC_W'(0));
            chk("R7 wb_illegal", VEC_W'(wb_illegal), VEC_W'(1));
        end
        @(negedge clk);
        chk("R1 ready after writeback", VEC_W'(in_ready), VEC_W'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset ready", VEC_W'(in_ready), VEC_W'(1));
        chk("R12 reset op_valid", VEC_W'(op_valid), VEC_W'(0));
        chk("R12 reset wb_valid", VEC_W'(wb_valid), VEC_W'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NVEC; n++) run_vec(VECS[n], 0);

        // directed: long stall in WAIT before results return
        run_vec(VECS[2], 4);
        run_vec(VECS[4], 2);

        // directed: results offered while idle must be ignored
        @(negedge clk);
        res_valid = 1'b1; res_data = {VEC_W{1'b1}}; res_flags = '1;
        @(negedge clk);
        res_valid = 1'b0;
        chk("R11 no wb from idle res", VEC_W'(wb_valid), VEC_W'(0));
        chk("R11 still idle", VEC_W'(in_ready), VEC_W'(1));
        @(negedge clk);
        chk("R11 no late wb", VEC_W'(wb_valid), VEC_W'(0));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule